// File: doc/BRIEF.md
# Load/Store Address Generator

This block computes the memory address for single-word and single-byte load and store instructions. From the 32-bit instruction word, the base register value, the index register value and the carry flag, it produces the access address in a single combinational pass. It also produces a base-register writeback request with the value to write back. Finally, it decodes the access attributes: direction, size, user-mode translation, and an undefined-encoding flag.

The offset is either a 12-bit unsigned immediate or the index register scaled by a shift whose amount is a constant taken from the instruction. A sign bit in the instruction chooses whether the offset is added or subtracted. The pre/post bit and the writeback bit together pick one of three addressing forms: post-indexed, plain offset, or pre-indexed with update. The block has no clock and no state. It sits between register read and the memory port of an execute stage. Memory access, data rotation and register-file writes all happen outside it.

Top module: `ls_agu`

## Requirements
- R1: When the offset-select bit inst[25] is 0, the offset is inst[11:0] zero-extended.
- R2: When the direction bit inst[23] is 1 the offset is added to the base; when it is 0 it is subtracted. This applies to both the address and the writeback value.
- R3: When the pre/post bit inst[24] is 0 (post-indexed), addr_o equals rn_i, wb_en_o is 1, and wb_val_o is rn_i plus or minus the offset.
- R4: When inst[24] is 1 and the writeback bit inst[21] is 0, addr_o is rn_i plus or minus the offset, wb_en_o is 0 and wb_val_o is 0.
- R5: When inst[24] is 1 and inst[21] is 1 (pre-indexed), addr_o is rn_i plus or minus the offset, wb_en_o is 1, and wb_val_o equals addr_o.
- R6: When inst[25] is 1, the offset is rm_i shifted by the amount in inst[11:7]. The shift kind comes from inst[6:5]: 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right. For the two right shifts, an amount of 0 means a shift by 32: the result is 0 for the logical shift and 32 copies of rm_i[31] for the arithmetic shift.
- R7: A rotate right with a non-zero amount rotates rm_i. A rotate right with amount 0 is a one-bit rotate through carry, giving {c_i, rm_i[31:1]}.
- R8: c_i has no effect on any output except in the rotate-through-carry case of R7.
- R9: is_load_o equals inst[20], and is_byte_o equals inst[22].
- R10: user_xlat_o is 1 exactly when inst[24] is 0 and inst[21] is 1.
- R11: When inst[25] is 1 and inst[4] is 1, undef_o is 1, wb_en_o is 0 and wb_val_o is 0. In every other case undef_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst_i | input | 32 | Instruction word |
| rn_i | input | DATA_W | Base register value |
| rm_i | input | DATA_W | Index register value |
| c_i | input | 1 | Carry flag, used only for rotate through carry |
| addr_o | output | DATA_W | Memory access address |
| wb_en_o | output | 1 | Base register writeback request |
| wb_val_o | output | DATA_W | Value to write back to the base register, 0 when no writeback |
| is_load_o | output | 1 | 1 for load, 0 for store |
| is_byte_o | output | 1 | 1 for byte access, 0 for word access |
| user_xlat_o | output | 1 | Access uses user-mode translation |
| undef_o | output | 1 | Undefined register-offset encoding |

## Verification
Every output is a purely combinational function of the current inputs, so each result is due in the same cycle as its stimulus, with zero register stages. The bench applies a new input vector on each falling clock edge and compares all outputs two nanoseconds later, well before the next rising edge. This keeps every comparison inside the same stable window.

The sweep covers all sixteen offset-select, pre/post, direction and writeback combinations. It crosses them with every shift kind, all 32 shift amounts, both carry values and both values of inst[4], on three base and index pairs chosen to produce carries, borrows and sign-fill cases.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int unsigned INST_W   = 32;
  localparam int unsigned IMM_W    = 12;
  localparam int unsigned SHAMT_W  = 5;

  localparam int unsigned B_REGOFF = 25;
  localparam int unsigned B_PRE    = 24;
  localparam int unsigned B_UP     = 23;
  localparam int unsigned B_BYTE   = 22;
  localparam int unsigned B_WB     = 21;
  localparam int unsigned B_LOAD   = 20;
  localparam int unsigned B_SHLO   = 7;
  localparam int unsigned B_KINDLO = 5;
  localparam int unsigned B_REGSH  = 4;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } sh_kind_e;

  typedef struct packed {
    logic               reg_off;
    logic               pre;
    logic               up;
    logic               byte_sel;
    logic               wb_bit;
    logic               load;
    logic               reg_shift;
    logic [SHAMT_W-1:0] shamt;
    sh_kind_e           kind;
    logic [IMM_W-1:0]   imm12;
  } ls_fields_t;
endpackage

// File: rtl/agu_decode.sv
module agu_decode
  import agu_pkg::*;
(
  input  logic [INST_W-1:0] inst_i,
  output ls_fields_t        fld_o,
  output logic              undef_o,
  output logic              user_xlat_o
);
  logic unused_bits;
  assign unused_bits = ^{inst_i[31:26], inst_i[19:12]};

  always_comb begin
    fld_o.reg_off   = inst_i[B_REGOFF];
    fld_o.pre       = inst_i[B_PRE];
    fld_o.up        = inst_i[B_UP];
    fld_o.byte_sel  = inst_i[B_BYTE];
    fld_o.wb_bit    = inst_i[B_WB];
    fld_o.load      = inst_i[B_LOAD];
    fld_o.reg_shift = inst_i[B_REGSH];
    fld_o.shamt     = inst_i[B_SHLO +: SHAMT_W];
    fld_o.kind      = sh_kind_e'(inst_i[B_KINDLO +: 2]);
    fld_o.imm12     = inst_i[IMM_W-1:0];
  end

  // register-specified shift amounts are not a legal offset form
  assign undef_o     = fld_o.reg_off & fld_o.reg_shift;
  assign user_xlat_o = ~fld_o.pre & fld_o.wb_bit;

  always_comb begin
    if (!inst_i[B_REGOFF]) p_no_undef_imm_r11: assert (!undef_o);
  end
endmodule

// File: rtl/agu_shifter.sv
module agu_shifter
  import agu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]  rm_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  sh_kind_e           kind_i,
  input  logic               c_i,
  output logic [DATA_W-1:0]  off_o
);
  localparam int unsigned DW2 = 2 * DATA_W;

  logic              amt_zero;
  logic [DW2-1:0]    rot_pair;
  logic [DW2-1:0]    rot_shifted;
  logic [DW2-1:0]    sext;
  logic [DW2-1:0]    asr_shifted;

  assign amt_zero    = (shamt_i == '0);
  assign rot_pair    = {rm_i, rm_i};
  assign rot_shifted = rot_pair >> shamt_i;
  assign sext        = {{DATA_W{rm_i[DATA_W-1]}}, rm_i};
  assign asr_shifted = sext >> shamt_i;

  always_comb begin
    unique case (kind_i)
      SH_LSL: off_o = rm_i << shamt_i;
      SH_LSR: off_o = amt_zero ? '0 : (rm_i >> shamt_i);
      SH_ASR: off_o = amt_zero ? {DATA_W{rm_i[DATA_W-1]}} : asr_shifted[DATA_W-1:0];
      SH_ROR: off_o = amt_zero ? {c_i, rm_i[DATA_W-1:1]} : rot_shifted[DATA_W-1:0];
      default: off_o = '0;
    endcase
  end

  always_comb begin
    if (kind_i == SH_LSR) p_lsr_msb_clear_r6: assert (!off_o[DATA_W-1]);
    if (kind_i == SH_ASR) p_asr_sign_kept_r6: assert (off_o[DATA_W-1] == rm_i[DATA_W-1]);
    if (kind_i == SH_LSL && amt_zero) p_lsl_zero_identity_r6: assert (off_o == rm_i);
    if (kind_i == SH_ROR && amt_zero) p_rrx_low_r7: assert (off_o[0] == rm_i[1]);
  end
endmodule

// File: rtl/agu_addsub.sv
module agu_addsub #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] off_i,
  input  logic              up_i,
  output logic [DATA_W-1:0] sum_o
);
  logic [DATA_W-1:0] operand_b;
  logic              cin;

  // subtraction as base + ~off + 1 to share one adder
  assign operand_b = up_i ? off_i : ~off_i;
  assign cin       = ~up_i;
  assign sum_o     = base_i + operand_b + {{(DATA_W-1){1'b0}}, cin};

  always_comb begin
    if (off_i == '0) p_zero_off_identity_r2: assert (sum_o == base_i);
  end
endmodule

// File: rtl/ls_agu.sv
module ls_agu
  import agu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [INST_W-1:0] inst_i,
  input  logic [DATA_W-1:0] rn_i,
  input  logic [DATA_W-1:0] rm_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] addr_o,
  output logic              wb_en_o,
  output logic [DATA_W-1:0] wb_val_o,
  output logic              is_load_o,
  output logic              is_byte_o,
  output logic              user_xlat_o,
  output logic              undef_o
);
  localparam int unsigned IMM_PAD = DATA_W - IMM_W;

  ls_fields_t        fld;
  logic              undef;
  logic [DATA_W-1:0] reg_off;
  logic [DATA_W-1:0] offset;
  logic [DATA_W-1:0] sum;
  logic              wb_req;

  agu_decode u_dec (
    .inst_i      (inst_i),
    .fld_o       (fld),
    .undef_o     (undef),
    .user_xlat_o (user_xlat_o)
  );

  agu_shifter #(.DATA_W(DATA_W)) u_shf (
    .rm_i    (rm_i),
    .shamt_i (fld.shamt),
    .kind_i  (fld.kind),
    .c_i     (c_i),
    .off_o   (reg_off)
  );

  assign offset = fld.reg_off ? reg_off : {{IMM_PAD{1'b0}}, fld.imm12};

  agu_addsub #(.DATA_W(DATA_W)) u_add (
    .base_i (rn_i),
    .off_i  (offset),
    .up_i   (fld.up),
    .sum_o  (sum)
  );

  assign wb_req    = (~fld.pre | fld.wb_bit) & ~undef;
  assign addr_o    = fld.pre ? sum : rn_i;
  assign wb_en_o   = wb_req;
  assign wb_val_o  = wb_req ? sum : '0;
  assign is_load_o = fld.load;
  assign is_byte_o = fld.byte_sel;
  assign undef_o   = undef;

  always_comb begin
    if (undef_o) p_undef_no_wb_r11: assert (!wb_en_o && wb_val_o == '0);
    if (!inst_i[B_PRE]) p_post_addr_base_r3: assert (addr_o == rn_i);
    if (inst_i[B_PRE] && inst_i[B_WB] && !undef_o) p_pre_wb_is_addr_r5: assert (wb_en_o && wb_val_o == addr_o);
    if (inst_i[B_PRE] && !inst_i[B_WB]) p_offset_no_wb_r4: assert (!wb_en_o);
    if (user_xlat_o) p_xlat_is_post_r10: assert (addr_o == rn_i);
  end
endmodule

// File: tb/ls_agu_tb_top.sv
module ls_agu_tb_top;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic [31:0]   inst;
  logic [DW-1:0] rn, rm;
  logic          c;
  logic [DW-1:0] addr, wb_val;
  logic          wb_en, is_load, is_byte, user_xlat, undef;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ls_agu #(.DATA_W(DW)) dut_i (
    .inst_i(inst), .rn_i(rn), .rm_i(rm), .c_i(c),
    .addr_o(addr), .wb_en_o(wb_en), .wb_val_o(wb_val),
    .is_load_o(is_load), .is_byte_o(is_byte),
    .user_xlat_o(user_xlat), .undef_o(undef)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s inst=%08h rn=%08h rm=%08h c=%0b act=%08h exp=%08h", req, inst, rn, rm, c, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] shift_model(input logic [DW-1:0] v, input int kind, input int amt, input logic cf);
    logic [63:0] wide;
    case (kind)
      0: return v << amt;
      1: return (amt == 0) ? 32'h0 : v >> amt;
      2: begin
        wide = {{32{v[31]}}, v};
        return (amt == 0) ? {32{v[31]}} : 32'(wide >> amt);
      end
      default: return (amt == 0) ? {cf, v[31:1]} : ((v >> amt) | (v << (32 - amt)));
    endcase
  endfunction

  initial begin
    #1500000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rn_set [3];
    logic [DW-1:0] rm_set [3];
    rn_set[0] = 32'h0000_1000; rm_set[0] = 32'h8000_0003;
    rn_set[1] = 32'hFFFF_FFF0; rm_set[1] = 32'h1234_5678;
    rn_set[2] = 32'h0000_0000; rm_set[2] = 32'hF0F0_0F0F;

    // all-zero vector: post-indexed store word, imm 0
    @(negedge clk);
    inst = 32'h0; rn = 32'h0; rm = 32'h0; c = 1'b0;
    #2;
    chk("R3 addr", addr, 32'h0);
    chk("R3 wb_en", 32'(wb_en), 32'd1);
    chk("R11 undef", 32'(undef), 32'd0);

    for (int m = 0; m < 16; m++) begin
      for (int t = 0; t < 4; t++) begin
        for (int a = 0; a < 32; a++) begin
          for (int x = 0; x < 4; x++) begin
            for (int d = 0; d < 3; d++) begin
              logic iflag, pflag, uflag, wflag, bflag, lflag, b4, cf;
              logic [DW-1:0] off, sum, e_addr, e_wbv;
              logic e_undef, e_wb;
              string oreq;
              iflag = m[3]; pflag = m[2]; uflag = m[1]; wflag = m[0];
              cf = x[0]; b4 = x[1];
              bflag = a[0] ^ d[0]; lflag = t[0] ^ x[0];
              @(negedge clk);
              inst = {4'hE, 2'b01, iflag, pflag, uflag, bflag, wflag, lflag,
                      4'h3, 4'h5, 5'(a), 2'(t), b4, 4'h7};
              rn = rn_set[d]; rm = rm_set[d]; c = cf;
              #2;
              if (iflag) begin
                off = shift_model(rm_set[d], t, a, cf);
                oreq = (t == 3 && a == 0) ? "R7" : (t == 3 ? "R7/R8" : "R6/R8");
              end else begin
                off = {20'h0, inst[11:0]};
                oreq = "R1";
              end
              sum = uflag ? rn_set[d] + off : rn_set[d] - off;
              e_undef = iflag & b4;
              e_wb = (!pflag || wflag) && !e_undef;
              e_addr = pflag ? sum : rn_set[d];
              e_wbv = e_wb ? sum : 32'h0;
              chk($sformatf("%s/R2 addr (R3 R4 R5)", oreq), addr, e_addr);
              chk(pflag ? (wflag ? "R5 wb_en" : "R4 wb_en") : "R3 wb_en", 32'(wb_en), 32'(e_wb));
              chk(e_undef ? "R11 wb_val" : "R2 wb_val", wb_val, e_wbv);
              chk("R11 undef", 32'(undef), 32'(e_undef));
              chk("R9 load", 32'(is_load), 32'(lflag));
              chk("R9 byte", 32'(is_byte), 32'(bflag));
              chk("R10 user_xlat", 32'(user_xlat), 32'(!pflag && wflag));
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule